// File: doc/BRIEF.md
# Block Write-Guard and Endurance-Block Configuration

This block holds the configuration that decides which parts of an 8K-byte serial memory array may be written. The array is split into sixteen 512-byte blocks. A contiguous secure region, given by a first block and a length of 0 to 15 blocks, is write-protected. One block, chosen separately, is marked as the high-endurance block. That block is always writable, even when it falls inside the secure region.

The serial bus slave passes every received data byte of a write transaction to this block, together with a pulse at each transaction start and one at each Stop. A transaction whose first address byte has its top bit set is a configuration command. The third byte then selects the target (secure region or endurance block) and the direction (set or read back). A setting takes effect only when the Stop arrives right after the third byte. A read request switches the two read-back bytes to the selected view straight away, so the slave can shift them out. The array write path asks, for each address, whether the byte may be stored. When it may not, the write path drops the byte without reporting an error.

Once the secure region has been given a non-zero length, the region and the endurance-block location can no longer be changed until reset.

Top module: `blkcfg_guard`

## Requirements
- R1: After reset the secure region starts at block 15 with length 0, the endurance block is 15, the read-back view is the secure view (`rb_first` = 8'hFF, `rb_second` = 8'hF0), and every address is writable.
- R2: A configuration set of the secure region is a write of exactly three bytes followed by Stop. Byte 0 has bit 7 = 1, and its bits 4..1 give the first block. Byte 2 has bit 7 = 1 and bit 6 = 0, and its bits 3..0 give the length. Bits 0, 5 and 6 of byte 0, all of byte 1, and bits 5..4 of byte 2 have no effect.
- R3: The same three-byte sequence with bit 7 = 0 and bit 6 = 0 in byte 2 moves the endurance block to the block number in bits 4..1 of byte 0.
- R4: A transaction whose byte 0 has bit 7 = 0, or one that ends with Stop after fewer or more than three bytes, leaves all settings unchanged.
- R5: While the secure length is non-zero, further secure-region sets and endurance-block moves are ignored.
- R6: A secure-region set with length 0 updates the first block and does not lock the configuration.
- R7: A third byte with bit 7 = 1 and bit 6 = 1 selects the secure view from the next cycle: `rb_first` = {4'hF, first block} and `rb_second` = {4'hF, length}. A read does not alter any setting.
- R8: A third byte with bit 7 = 0 and bit 6 = 1 selects the endurance view from the next cycle: `rb_first` = {4'hF, endurance block} and `rb_second` = 8'hFF.
- R9: The block of `wr_addr` is bits 12..9. It is protected when first ≤ block < first + length, with the range clipped at block 15 rather than wrapping to block 0. `wr_ok` is 0 for a protected block.
- R10: `wr_ok` is 1 for any address in the endurance block, even if that block lies in the secure region.
- R11: Settings change only in the cycle after the Stop pulse is sampled. Receiving all three bytes without a Stop changes nothing.

Top module port list order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | Pulse: a new write transaction header was received |
| byte_vld | input | 1 | Pulse: `byte_data` holds the next received byte |
| byte_data | input | 8 | Received byte |
| stop_seen | input | 1 | Pulse: Stop condition on the bus |
| wr_addr | input | 13 | Array address being written |
| wr_ok | output | 1 | 1 when the byte at `wr_addr` may be stored |
| rb_first | output | 8 | First read-back byte of the selected view |
| rb_second | output | 8 | Second read-back byte of the selected view |
| he_block | output | 4 | Current endurance block index |

## Verification
A wrong first block or length shows up on `wr_ok` for some block as soon as the bench sweeps all sixteen block indices. It also shows in the low nibbles of the read-back bytes one cycle after a secure-view read. A wrong endurance index appears at once on `he_block`. A lock flag that is set when it should not be, or missed when it should be, only shows one transaction later, when a set that should have been ignored, or applied, changes, or fails to change, those same outputs. The bench therefore follows each step with a read-back and a sweep of `wr_ok`.

// File: rtl/blkcfg_pkg.sv
package blkcfg_pkg;
  parameter int BLK_W = 4;
  typedef logic [BLK_W-1:0] blk_t;

  typedef struct packed {
    blk_t first;
    blk_t len;
    blk_t he;
  } cfg_t;

  // block index from an array address
  function automatic blk_t blk_of(input logic [12:0] addr);
    return addr[12:12-BLK_W+1];
  endfunction

  // inside [first, first+len) with one extra bit so the sum clips, not wraps
  function automatic logic in_window(input blk_t b, input blk_t first, input blk_t len);
    logic [BLK_W:0] lo, hi, x;
    lo = {1'b0, first};
    hi = {1'b0, first} + {1'b0, len};
    x  = {1'b0, b};
    return (x >= lo) && (x < hi);
  endfunction
endpackage

// File: rtl/blkcfg_seq.sv
module blkcfg_seq
  import blkcfg_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              stop_seen,
  output logic              apply_sec,
  output logic              apply_he,
  output blk_t              new_blk,
  output blk_t              new_len,
  output logic              view_upd,
  output logic              view_he
);
  localparam int CFG_BIT = BYTE_W - 1;
  localparam int SEL_BIT = BYTE_W - 1;
  localparam int RD_BIT  = BYTE_W - 2;
  localparam int CNT_W   = 3;
  localparam logic [CNT_W-1:0] N_FULL = 3'd3;
  localparam logic [CNT_W-1:0] N_SAT  = 3'd4;

  logic [CNT_W-1:0]  n_seen;
  logic [BYTE_W-1:0] b0_q, b2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_seen <= '0;
      b0_q   <= '0;
      b2_q   <= '0;
    end else if (txn_start || stop_seen) begin
      n_seen <= '0;
    end else if (byte_vld) begin
      if (n_seen != N_SAT) n_seen <= n_seen + 1'b1;
      if (n_seen == 3'd0) b0_q <= byte_data;
      if (n_seen == 3'd2) b2_q <= byte_data;
    end
  end

  logic seq_ok;
  assign seq_ok    = stop_seen && (n_seen == N_FULL) && b0_q[CFG_BIT] && !b2_q[RD_BIT];
  assign apply_sec = seq_ok && b2_q[SEL_BIT];
  assign apply_he  = seq_ok && !b2_q[SEL_BIT];
  assign new_blk   = b0_q[BLK_W:1];
  assign new_len   = b2_q[BLK_W-1:0];
  assign view_upd  = byte_vld && !txn_start && !stop_seen && (n_seen == 3'd2)
                     && b0_q[CFG_BIT] && byte_data[RD_BIT];
  assign view_he   = !byte_data[SEL_BIT];

  a_r4_apply_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_sec || apply_he) |-> stop_seen);
  a_r3_single_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({apply_sec, apply_he, view_upd}));
endmodule

// File: rtl/blkcfg_regs.sv
module blkcfg_regs
  import blkcfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic apply_sec,
  input  logic apply_he,
  input  blk_t new_blk,
  input  blk_t new_len,
  input  logic view_upd,
  input  logic view_he,
  output cfg_t cfg_q,
  output logic view_is_he
);
  localparam blk_t BLK_TOP = blk_t'((1 << BLK_W) - 1);

  logic locked;
  assign locked = (cfg_q.len != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.first <= BLK_TOP;
      cfg_q.len   <= '0;
      cfg_q.he    <= BLK_TOP;
      view_is_he  <= 1'b0;
    end else begin
      if (apply_sec && !locked) begin
        cfg_q.first <= new_blk;
        cfg_q.len   <= new_len;
      end
      if (apply_he && !locked) cfg_q.he <= new_blk;
      if (view_upd) view_is_he <= view_he;
    end
  end

  a_r5_frozen_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.len != '0) |=> $stable(cfg_q));
  a_r11_hold_without_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !(apply_sec || apply_he) |=> $stable(cfg_q));
  a_r7_read_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    view_upd |=> $stable(cfg_q));
endmodule

// File: rtl/blkcfg_perm.sv
module blkcfg_perm
  import blkcfg_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg_q,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              wr_ok
);
  blk_t wr_blk;
  logic in_sec;

  always_comb begin
    wr_blk = blk_of(wr_addr);
    in_sec = in_window(wr_blk, cfg_q.first, cfg_q.len);
    wr_ok  = !in_sec || (wr_blk == cfg_q.he);
  end

  a_r10_he_writable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr[ADDR_W-1:ADDR_W-BLK_W] == cfg_q.he) |-> wr_ok);
  a_r9_zero_len_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.len == '0) |-> wr_ok);
  a_r9_below_first_open: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr[ADDR_W-1:ADDR_W-BLK_W] < cfg_q.first) |-> wr_ok);
endmodule

// File: rtl/blkcfg_guard.sv
module blkcfg_guard
  import blkcfg_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              stop_seen,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              wr_ok,
  output logic [BYTE_W-1:0] rb_first,
  output logic [BYTE_W-1:0] rb_second,
  output logic [BLK_W-1:0]  he_block
);
  localparam int PAD_W = BYTE_W - BLK_W;
  localparam logic [PAD_W-1:0] PAD = '1;

  logic apply_sec, apply_he, view_upd, view_he, view_is_he;
  blk_t new_blk, new_len;
  cfg_t cfg_q;

  blkcfg_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .byte_vld(byte_vld),
    .byte_data(byte_data), .stop_seen(stop_seen), .apply_sec(apply_sec),
    .apply_he(apply_he), .new_blk(new_blk), .new_len(new_len),
    .view_upd(view_upd), .view_he(view_he)
  );

  blkcfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .apply_sec(apply_sec), .apply_he(apply_he),
    .new_blk(new_blk), .new_len(new_len), .view_upd(view_upd),
    .view_he(view_he), .cfg_q(cfg_q), .view_is_he(view_is_he)
  );

  blkcfg_perm #(.ADDR_W(ADDR_W)) u_perm (
    .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .wr_addr(wr_addr), .wr_ok(wr_ok)
  );

  assign rb_first  = {PAD, (view_is_he ? cfg_q.he : cfg_q.first)};
  assign rb_second = view_is_he ? '1 : {PAD, cfg_q.len};
  assign he_block  = cfg_q.he;

  a_r8_he_view_pad: assert property (@(posedge clk) disable iff (!rst_n)
    $past(view_upd && view_he) |-> (rb_second == '1));
endmodule

// File: tb/tb_blkcfg_guard.sv
`timescale 1ns/1ps
module tb_blkcfg_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txn_start = 1'b0, byte_vld = 1'b0, stop_seen = 1'b0;
  logic [7:0] byte_data = '0;
  logic [12:0] wr_addr = '0;
  logic wr_ok;
  logic [7:0] rb_first, rb_second;
  logic [3:0] he_block;

  int n_chk = 0, n_bad = 0;
  int m_first, m_len, m_he;
  bit m_view_he;

  always #2 clk = ~clk;

  blkcfg_guard dut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .byte_vld(byte_vld),
    .byte_data(byte_data), .stop_seen(stop_seen), .wr_addr(wr_addr),
    .wr_ok(wr_ok), .rb_first(rb_first), .rb_second(rb_second), .he_block(he_block)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_first = 15; m_len = 0; m_he = 15; m_view_he = 0;
  endtask

  task automatic check_state(input string req);
    check({req, " he_block"}, he_block, m_he);
    check({req, " rb_first"}, rb_first, m_view_he ? (8'hF0 | m_he) : (8'hF0 | m_first));
    check({req, " rb_second"}, rb_second, m_view_he ? 8'hFF : (8'hF0 | m_len));
  endtask

  task automatic check_perm(input string req);
    for (int b = 0; b < 16; b++) begin
      bit prot = 0;
      for (int k = 0; k < m_len; k++) if (m_first + k == b) prot = 1;
      wr_addr = 13'((b << 9) | 9'h1A5);
      #1;
      check($sformatf("%s wr_ok blk %0d", req, b), wr_ok, (!prot || b == m_he) ? 1 : 0);
    end
  endtask

  task automatic send_byte(input logic [7:0] d);
    byte_vld = 1'b1; byte_data = d;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic txn(input logic [7:0] b0, b1, b2, b3, input int n);
    logic [7:0] bs [4];
    bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
    @(negedge clk);
    txn_start = 1'b1;
    @(negedge clk);
    txn_start = 1'b0;
    for (int i = 0; i < n; i++) send_byte(bs[i]);
    stop_seen = 1'b1;
    @(negedge clk);
    stop_seen = 1'b0;
  endtask

  // R1
  task automatic t_reset();
    do_reset();
    check_state("R1");
    check_perm("R1");
  endtask

  // R4: non-config and wrong-length sequences
  task automatic t_ignored();
    txn(8'h0A, 8'h00, 8'h83, 8'h00, 3);
    check_state("R4 non-config");
    txn(8'h8A, 8'h00, 8'h83, 8'h00, 2);
    check_state("R4 short");
    txn(8'h8A, 8'h00, 8'h83, 8'h00, 4);
    check_state("R4 long");
    check_perm("R4");
  endtask

  // R3, R11: endurance move applied only at Stop
  task automatic t_he_move();
    @(negedge clk);
    txn_start = 1'b1;
    @(negedge clk);
    txn_start = 1'b0;
    send_byte(8'hE7);
    send_byte(8'h5A);
    send_byte(8'h30);
    repeat (2) @(negedge clk);
    check("R11 before stop", he_block, 15);
    stop_seen = 1'b1;
    @(negedge clk);
    stop_seen = 1'b0;
    m_he = 3;
    check_state("R3 after stop");
  endtask

  // R8
  task automatic t_he_read();
    txn(8'h80, 8'h00, 8'h40, 8'h00, 3);
    m_view_he = 1;
    check_state("R8");
  endtask

  // R6, R7
  task automatic t_zero_len();
    txn(8'h8A, 8'h00, 8'h80, 8'h00, 3);
    m_first = 5;
    check_state("R6 view unchanged");
    txn(8'h80, 8'h00, 8'hC0, 8'h00, 3);
    m_view_he = 0;
    check_state("R7 secure view");
    check_perm("R6 still open");
    txn(8'h92, 8'h00, 8'h00, 8'h00, 3);
    m_he = 9;
    check_state("R6 unlocked");
    txn(8'h86, 8'h00, 8'h00, 8'h00, 3);
    m_he = 3;
    check_state("R6 unlocked back");
  endtask

  // R2, R9, R10
  task automatic t_secure_set();
    txn(8'hE5, 8'h5A, 8'hB4, 8'h00, 3);
    m_first = 2; m_len = 4;
    check_state("R2");
    check_perm("R9 R10");
  endtask

  // R5
  task automatic t_locked();
    txn(8'h80, 8'h00, 8'h81, 8'h00, 3);
    check_state("R5 secure ignored");
    txn(8'h92, 8'h00, 8'h00, 8'h00, 3);
    check_state("R5 he ignored");
    check_perm("R5");
  endtask

  // R9 clip, R10 default block inside range
  task automatic t_clip();
    do_reset();
    txn(8'hFB, 8'h00, 8'hB7, 8'h00, 3);
    m_first = 13; m_len = 7;
    check_state("R2 junk bits");
    check_perm("R9 clip R10");
  endtask

  initial begin
    t_reset();
    t_ignored();
    t_he_move();
    t_he_read();
    t_zero_len();
    t_secure_set();
    t_locked();
    t_clip();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule